// File: doc/BRIEF.md
# Two-Class Interrupt Status and Enable Controller

This block gathers interrupt requests for two classes, a normal class (IRQ) and a fast class (FIQ). Each class has a vector of source lines coming from elsewhere on the chip and its own enable mask. Software reads each class's sources through two views: the unfiltered source vector, and the source vector filtered by the mask. It never writes a mask as a whole word. It turns enable bits on through a set alias and off through a clear alias, each of which changes only the bits written as one. The block raises one request line per class when any enabled source of that class is active.

The access port carries one request per cycle: a write or a read with a three-bit address. Read data and the error flag are registered and become valid in the cycle after the request. An illegal access changes no state. It raises the error flag for one cycle and returns zero.

Top module: `intc_ctrl`

## Requirements
- R1: Address bit 2 picks the class (0 = IRQ, 1 = FIQ). Address bits 1:0 pick the register: 0 = masked status, 1 = raw status, 2 = enable-set, 3 = enable-clear. Read data and the error flag appear in the cycle after the request.
- R2: A read of masked status returns the class's source vector bitwise-ANDed with its enable mask.
- R3: A read of raw status returns the class's source vector unmasked.
- R4: A write to enable-set ORs the written bits into the class's mask.
- R5: A write to enable-clear removes the written bits from the class's mask and leaves the other bits unchanged.
- R6: A write to masked or raw status of either class changes no mask and sets the error flag in the following cycle.
- R7: A read of the IRQ enable-set or enable-clear address sets the error flag and returns zero.
- R8: A read of the FIQ enable-set or enable-clear address returns zero and does not set the error flag.
- R9: After reset both masks are zero, both request outputs are low, and read data and the error flag are zero.
- R10: Each request output is the OR of its class's masked status. It follows a mask write in the next cycle and follows a change on a source line in the same cycle.
- R11: A write aimed at one class leaves the other class's mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NSRC | IRQ-class source lines |
| src_fiq | input | NSRC | FIQ-class source lines |
| acc_req | input | 1 | Access request, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Class and register select |
| acc_wdata | input | NSRC | Write data |
| rsp_rdata | output | NSRC | Registered read data |
| rsp_err | output | 1 | Illegal-access flag, one cycle |
| irq_o | output | 1 | IRQ-class request |
| fiq_o | output | 1 | FIQ-class request |

## Verification
The enable masks are built up one bit at a time across all 32 positions of each class while every IRQ source is held high. This exposes a stuck or misrouted mask bit, and it shows that set writes accumulate rather than overwrite. The masks are then cleared at every even position against an FIQ source pattern that is only partly active, which separates clearing from masking. Raw reads are checked under all-zero, all-one, alternating and walking-one source patterns to catch swapped or dropped lines. The illegal writes and reads in both classes, and the request outputs under source toggles, show that the error flag and the outputs depend on the class and register as required.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W  = 3;
  localparam int NCLASS  = 2;
  localparam int CLS_IRQ = 0;
  localparam int CLS_FIQ = 1;

  typedef enum logic [1:0] {
    OFS_MASKED = 2'd0,
    OFS_RAW    = 2'd1,
    OFS_SET    = 2'd2,
    OFS_CLR    = 2'd3
  } ofs_e;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
(
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NCLASS-1:0] set_we,
  output logic [NCLASS-1:0] clr_we,
  output logic              rd_en,
  output logic              rd_cls,
  output ofs_e              rd_ofs,
  output logic              illegal
);
  ofs_e ofs;
  logic cls;
  logic wr_acc;
  logic rd_acc;

  always_comb begin
    ofs    = ofs_e'(acc_addr[1:0]);
    cls    = acc_addr[2];
    wr_acc = acc_req && acc_wr;
    rd_acc = acc_req && !acc_wr;
    set_we = '0;
    clr_we = '0;
    if (wr_acc && ofs == OFS_SET) set_we[cls] = 1'b1;
    if (wr_acc && ofs == OFS_CLR) clr_we[cls] = 1'b1;
    rd_en   = rd_acc;
    rd_cls  = cls;
    rd_ofs  = ofs;
    illegal = (wr_acc && (ofs == OFS_MASKED || ofs == OFS_RAW)) ||
              (rd_acc && cls == 1'(CLS_IRQ) && (ofs == OFS_SET || ofs == OFS_CLR));
  end
endmodule

// File: rtl/intc_class.sv
module intc_class #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] masked,
  output logic            req_o
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] mask_d;
  logic            mask_en;

  always_comb begin
    mask_en = set_we || clr_we;
    mask_d  = mask_q;
    if (set_we) mask_d = mask_q | wdata;
    if (clr_we) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign masked = src & mask_q;
  assign req_o  = |masked;

  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wdata)) == $past(wdata)) &&
               ((mask_q & $past(mask_q)) == $past(mask_q)));

  // R5
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(wdata)) == '0) &&
               ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(mask_q));

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !req_o);
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic [NSRC-1:0]   src_fiq,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NSRC-1:0]   acc_wdata,
  output logic [NSRC-1:0]   rsp_rdata,
  output logic              rsp_err,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NCLASS-1:0] set_we;
  logic [NCLASS-1:0] clr_we;
  logic              rd_en;
  logic              rd_cls;
  ofs_e              rd_ofs;
  logic              illegal;

  logic [NSRC-1:0]   src_v    [NCLASS];
  logic [NSRC-1:0]   masked_v [NCLASS];
  logic [NCLASS-1:0] req_v;

  logic [NSRC-1:0]   rd_val;
  logic [NSRC-1:0]   rdata_d;
  logic [NSRC-1:0]   rdata_q;
  logic              err_d;
  logic              err_q;

  assign src_v[CLS_IRQ] = src_irq;
  assign src_v[CLS_FIQ] = src_fiq;

  intc_decode u_decode (
    .acc_req  (acc_req),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .rd_en    (rd_en),
    .rd_cls   (rd_cls),
    .rd_ofs   (rd_ofs),
    .illegal  (illegal)
  );

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    intc_class #(.NSRC(NSRC)) u_class (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_v[c]),
      .set_we (set_we[c]),
      .clr_we (clr_we[c]),
      .wdata  (acc_wdata),
      .masked (masked_v[c]),
      .req_o  (req_v[c])
    );
  end

  always_comb begin
    case (rd_ofs)
      OFS_MASKED: rd_val = masked_v[rd_cls];
      OFS_RAW:    rd_val = src_v[rd_cls];
      default:    rd_val = '0;
    endcase
    rdata_d = rdata_q;
    if (rd_en) rdata_d = illegal ? '0 : rd_val;
    err_d = acc_req && illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
  assign irq_o     = req_v[CLS_IRQ];
  assign fiq_o     = req_v[CLS_FIQ];

  // R6
  status_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_wr && !acc_addr[1]) |=> rsp_err);

  // R7
  irq_en_rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_wr && !acc_addr[2] && acc_addr[1]) |=> (rsp_err && rsp_rdata == '0));

  // R8
  fiq_en_rd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_wr && acc_addr[2] && acc_addr[1]) |=> (!rsp_err && rsp_rdata == '0));

  // R3
  raw_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_wr && acc_addr[1:0] == 2'd1 && $stable(src_irq) && $stable(src_fiq))
      |=> (rsp_rdata == (acc_addr[2] ? $past(src_fiq) : $past(src_irq))));
endmodule

// File: tb/intc_ctrl_bench.sv
`timescale 1ns/1ps
module intc_ctrl_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_irq;
  logic [N-1:0]  src_fiq;
  logic          acc_req;
  logic          acc_wr;
  logic [2:0]    acc_addr;
  logic [N-1:0]  acc_wdata;
  logic [N-1:0]  rsp_rdata;
  logic          rsp_err;
  logic          irq_o;
  logic          fiq_o;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] m_mask [2];

  always #2.5 clk = ~clk;

  intc_ctrl #(.NSRC(N)) u_intc_ctrl (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .src_fiq(src_fiq),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = w; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_req = 1'b0; acc_wr = 1'b0;
  endtask

  function automatic logic [N-1:0] src_of(input int c);
    return (c == 0) ? src_irq : src_fiq;
  endfunction

  task automatic chk_outs(input string tag);
    chk({tag, " irq_o"}, N'(irq_o), N'(|(src_irq & m_mask[0])));
    chk({tag, " fiq_o"}, N'(fiq_o), N'(|(src_fiq & m_mask[1])));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] pats [4];
    pats[0] = '0; pats[1] = '1; pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h0000_8001;
    rst_n = 1'b0; acc_req = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    src_irq = '0; src_fiq = '0;
    m_mask[0] = '0; m_mask[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rdata", rsp_rdata, '0);
    chk("R9 err", N'(rsp_err), '0);
    chk("R9 irq_o", N'(irq_o), '0);
    chk("R9 fiq_o", N'(fiq_o), '0);
    src_irq = '1; src_fiq = '1;
    #1;
    chk_outs("R9 masks zero");
    acc(1'b0, 3'd0, '0); chk("R9 irq masked", rsp_rdata, '0);
    acc(1'b0, 3'd4, '0); chk("R9 fiq masked", rsp_rdata, '0);

    // R3 raw reads, class select R1
    for (int p = 0; p < 4; p++) begin
      src_irq = pats[p]; src_fiq = ~pats[p];
      acc(1'b0, 3'd1, '0); chk("R3 irq raw", rsp_rdata, pats[p]);
      acc(1'b0, 3'd5, '0); chk("R3 fiq raw", rsp_rdata, ~pats[p]);
    end
    for (int b = 0; b < N; b++) begin
      src_irq = N'(1) << b; src_fiq = ~(N'(1) << b);
      acc(1'b0, 3'd1, '0); chk("R3 irq walk", rsp_rdata, src_irq);
      acc(1'b0, 3'd5, '0); chk("R3 fiq walk", rsp_rdata, src_fiq);
    end

    // R4 set sweep, R2 masked reads, R10 outputs, R11 independence
    src_irq = '1; src_fiq = 32'h0F0F_3C3C;
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < N; b++) begin
        acc(1'b1, {c[0], 2'd2}, N'(1) << b);
        m_mask[c] = m_mask[c] | (N'(1) << b);
        chk_outs("R10 after set");
        acc(1'b0, {c[0], 2'd0}, '0);
        chk("R4 R2 masked after set", rsp_rdata, src_of(c) & m_mask[c]);
      end
      acc(1'b0, {~c[0], 2'd0}, '0);
      chk("R11 other class", rsp_rdata, src_of(1 - c) & m_mask[1 - c]);
    end

    // R5 clear even bits
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < N; b += 2) begin
        acc(1'b1, {c[0], 2'd3}, N'(1) << b);
        m_mask[c] = m_mask[c] & ~(N'(1) << b);
        acc(1'b0, {c[0], 2'd0}, '0);
        chk("R5 masked after clear", rsp_rdata, src_of(c) & m_mask[c]);
      end
    end

    // R10 source toggles reflected same cycle
    @(negedge clk);
    src_irq = 32'h5555_5555; src_fiq = 32'h0000_0001;
    #1 chk_outs("R10 sources off mask");
    src_irq = 32'h0000_0002; src_fiq = 32'h0000_0002;
    #1 chk_outs("R10 sources on mask");

    // R6 illegal status writes
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 2; r++) begin
        acc(1'b1, {c[0], 1'b0, r[0]}, '1);
        chk("R6 err", N'(rsp_err), N'(1));
        acc(1'b0, {c[0], 2'd0}, '0);
        chk("R6 no err on legal read", N'(rsp_err), '0);
        chk("R6 mask unchanged", rsp_rdata, src_of(c) & m_mask[c]);
      end
    end

    // R7 IRQ enable reads illegal; R8 FIQ enable reads legal zero
    for (int r = 2; r < 4; r++) begin
      acc(1'b0, 3'd1, '0);
      acc(1'b0, {1'b0, r[1:0]}, '0);
      chk("R7 err", N'(rsp_err), N'(1));
      chk("R7 rdata", rsp_rdata, '0);
      acc(1'b0, 3'd5, '0);
      acc(1'b0, {1'b1, r[1:0]}, '0);
      chk("R8 err", N'(rsp_err), '0);
      chk("R8 rdata", rsp_rdata, '0);
    end

    // R5 R10 clear all
    src_irq = '1; src_fiq = '1;
    acc(1'b1, 3'd3, '1); m_mask[0] = '0;
    chk_outs("R10 irq cleared");
    acc(1'b1, 3'd7, '1); m_mask[1] = '0;
    chk_outs("R10 fiq cleared");
    acc(1'b0, 3'd0, '0); chk("R5 irq all clear", rsp_rdata, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule